// File: doc/BRIEF.md
# Reconfigurable Two-Table Logic Slice

This block models a single programmable logic cell built around two 16-entry, 1-bit lookup tables (table A and table B). A 2-bit mode register, run as a small state machine, decides how those two tables are used. In combinational lookup, each table implements any function of four inputs, or both join into a five-input function. In arithmetic, the tables are bypassed and a 2-bit adder/subtractor with magnitude compare drives the outputs. In memory, the tables become one writable 16-word by 2-bit store. In read-only, they serve as two independent 16x1 tables.

Table contents are loaded one whole 16-bit word at a time through a configuration write port. Software-free use is assumed: the surrounding logic writes the tables, then selects a mode, then drives the functional inputs. The parameter `HAS_RAM` builds either the full cell or a reduced cell that refuses the memory mode. A refused request raises an error flag and leaves the current mode in place.

The mode register has four states, named after the mode codes: LOGIC (00), ARITH (01), RAM (10) and ROM (11). Every transition is taken on a clock edge where `mode_we` is high, and it goes to the state whose code is on `mode_req`. There is one exception. On the reduced cell, a request for RAM leaves the state unchanged and sets the error flag (the REJECT transition). Any accepted request clears the flag. With `mode_we` low, both the state and the flag hold.

Top module: `cfg_slice`

## Requirements
- R1: After reset the mode reads 00 (LOGIC), the error flag is 0, and both tables hold all zeros, so `out_f0`, `out_f1` and `out_f5` are 0 for every input.
- R2: A request with `mode_we` high and an accepted code (00 LOGIC, 01 ARITH, 10 RAM, 11 ROM) appears on `mode_q` after the next rising edge. With `mode_we` low, `mode_q` holds.
- R3: In LOGIC mode, `out_f0` equals bit `in_a` of table A and `out_f1` equals bit `in_b` of table B, where the input value is the bit index.
- R4: In LOGIC mode, `out_f5` equals bit `in_a` of table B when `in_sel` is 1, and bit `in_a` of table A when `in_sel` is 0. In every other mode `out_f5` is 0.
- R5: In ARITH mode with `arith_sub` low, {`carry_out`, `out_f1`, `out_f0`} equals `in_a[1:0]` + `in_b[1:0]` + `carry_in`.
- R6: In ARITH mode with `arith_sub` high, {`carry_out`, `out_f1`, `out_f0`} equals `in_a[1:0]` + ~`in_b[1:0]` + `carry_in`. A carry out of 1 therefore means no borrow.
- R7: In ARITH mode, `cmp_ge`, `cmp_ne` and `cmp_le` report a>=b, a!=b and a<=b for a=`in_a[1:0]` and b=`in_b[1:0]`. In the other modes these outputs and `carry_out` are 0.
- R8: In RAM mode, {`out_f1`, `out_f0`} reads {table B, table A} at address `in_a` without a clock. With `ram_we` high, a rising edge writes `ram_wdata[0]` into table A and `ram_wdata[1]` into table B at `in_a`, and the new word is visible on the outputs after that edge.
- R9: In ROM mode, `out_f0` is bit `in_a` of table A and `out_f1` is bit `in_b` of table B. In ROM, LOGIC and ARITH modes `ram_we` never changes the table contents.
- R10: A rising edge with `cfg_we` high replaces the whole table chosen by `cfg_sel` (0 = A, 1 = B) with `cfg_init`, where bit i becomes entry i. This works in any mode. When it coincides with a RAM write, the configuration write wins and the RAM write is dropped for both tables.
- R11: On the reduced cell (`HAS_RAM` = 0), a request for code 10 leaves `mode_q` unchanged and sets `mode_err` after the edge.
- R12: `mode_err` holds its value while `mode_we` is low. It is cleared by the next accepted mode request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table load strobe |
| cfg_sel | input | 1 | Table to load: 0 = A, 1 = B |
| cfg_init | input | 16 | Table contents, bit i to entry i |
| mode_we | input | 1 | Mode change strobe |
| mode_req | input | 2 | Requested mode code |
| in_a | input | 4 | Table A index, RAM address, arithmetic operand a in bits 1:0 |
| in_b | input | 4 | Table B index, arithmetic operand b in bits 1:0 |
| in_sel | input | 1 | Fifth input of the five-input function |
| carry_in | input | 1 | Arithmetic carry in |
| arith_sub | input | 1 | 1 selects subtraction |
| ram_we | input | 1 | Memory write strobe |
| ram_wdata | input | 2 | Memory write word, bit 0 to table A |
| mode_q | output | 2 | Current mode code |
| mode_err | output | 1 | Last mode request was refused |
| out_f0 | output | 1 | Output 0 (table A, sum bit 0 or memory bit 0) |
| out_f1 | output | 1 | Output 1 (table B, sum bit 1 or memory bit 1) |
| out_f5 | output | 1 | Five-input function output |
| carry_out | output | 1 | Arithmetic carry out |
| cmp_ge | output | 1 | a >= b |
| cmp_ne | output | 1 | a != b |
| cmp_le | output | 1 | a <= b |

## Verification
The memory-write property assumes that a RAM write is not paired with a mode change or a table load in the same cycle. It also judges the following cycle only when `in_a` is unchanged. The stimulus keeps to this by raising `ram_we` alone, holding the address across the edge, and testing the load-versus-write collision separately at the ports. The mode properties take `mode_req` to be a defined 2-bit code whenever `mode_we` is high, and every request the bench issues is one of the four codes. The arithmetic checks assume the inputs are stable between the driving edge and the sampling point; the bench changes them only on falling edges.

// File: rtl/cfg_slice_pkg.sv
package cfg_slice_pkg;

    // Operating mode of the slice; the codes are the values seen on mode_q.
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ARITH = 2'b01,
        MODE_RAM   = 2'b10,
        MODE_ROM   = 2'b11
    } slice_mode_e;

endpackage

// File: rtl/cfg_slice_mode_fsm.sv
module cfg_slice_mode_fsm
    import cfg_slice_pkg::*;
#(
    parameter int HAS_RAM = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [1:0]  mode_req,
    output slice_mode_e state,
    output logic        err
);

    slice_mode_e state_q, state_d;
    logic        err_q, err_d;
    logic        ram_allowed;

    // The variant decides whether the memory state can be entered.
    generate
        if (HAS_RAM != 0) begin : g_full
            assign ram_allowed = 1'b1;
        end else begin : g_reduced
            assign ram_allowed = 1'b0;
        end
    endgenerate

    // Next-state logic: one transition per requested code.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        if (mode_we) begin
            unique case (mode_req)
                2'b00: begin
                    state_d = MODE_LOGIC;
                    err_d   = 1'b0;
                end
                2'b01: begin
                    state_d = MODE_ARITH;
                    err_d   = 1'b0;
                end
                2'b10: begin
                    if (ram_allowed) begin
                        state_d = MODE_RAM;
                        err_d   = 1'b0;
                    end else begin
                        err_d   = 1'b1;   // REJECT: stay put
                    end
                end
                2'b11: begin
                    state_d = MODE_ROM;
                    err_d   = 1'b0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_LOGIC;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    assign state = state_q;
    assign err   = err_q;

endmodule

// File: rtl/cfg_slice_table.sv
module cfg_slice_table #(
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_we,
    input  logic [(1<<IDX_W)-1:0] load_word,
    input  logic                  bit_we,
    input  logic [IDX_W-1:0]      bit_addr,
    input  logic                  bit_d,
    input  logic [IDX_W-1:0]      rd_addr_p,
    input  logic [IDX_W-1:0]      rd_addr_s,
    output logic                  rd_p,
    output logic                  rd_s
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] cells_q;

    // A whole-word load takes priority over a single-entry write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else if (load_we) begin
            cells_q <= load_word;
        end else if (bit_we) begin
            cells_q[bit_addr] <= bit_d;
        end
    end

    // Two asynchronous read ports.
    assign rd_p = cells_q[rd_addr_p];
    assign rd_s = cells_q[rd_addr_s];

endmodule

// File: rtl/cfg_slice_ripple.sv
module cfg_slice_ripple #(
    parameter int W = 2
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ge,
    output logic         ne,
    output logic         le
);

    logic [W-1:0] b_eff;
    logic [W:0]   total;

    always_comb begin
        b_eff = sub ? ~op_b : op_b;
        total = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end

    assign sum  = total[W-1:0];
    assign cout = total[W];
    assign ge   = (op_a >= op_b);
    assign ne   = (op_a != op_b);
    assign le   = (op_a <= op_b);

endmodule

// File: rtl/cfg_slice.sv
module cfg_slice
    import cfg_slice_pkg::*;
#(
    parameter int HAS_RAM = 1,
    parameter int IDX_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [(1<<IDX_W)-1:0] cfg_init,
    input  logic                  mode_we,
    input  logic [1:0]            mode_req,
    input  logic [IDX_W-1:0]      in_a,
    input  logic [IDX_W-1:0]      in_b,
    input  logic                  in_sel,
    input  logic                  carry_in,
    input  logic                  arith_sub,
    input  logic                  ram_we,
    input  logic [1:0]            ram_wdata,
    output logic [1:0]            mode_q,
    output logic                  mode_err,
    output logic                  out_f0,
    output logic                  out_f1,
    output logic                  out_f5,
    output logic                  carry_out,
    output logic                  cmp_ge,
    output logic                  cmp_ne,
    output logic                  cmp_le
);

    localparam int N_TAB   = 2;
    localparam int ARITH_W = 2;

    slice_mode_e      mode;
    logic             ram_wr;
    logic [N_TAB-1:0] rd_p;
    logic [N_TAB-1:0] rd_s;
    logic [ARITH_W-1:0] a_sum;
    logic             a_cout, a_ge, a_ne, a_le;

    cfg_slice_mode_fsm #(
        .HAS_RAM (HAS_RAM)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .mode_req (mode_req),
        .state    (mode),
        .err      (mode_err)
    );

    // Memory writes only in RAM mode and never alongside a table load.
    assign ram_wr = (mode == MODE_RAM) && ram_we && !cfg_we;

    // Table 0 (A) reads in_a on both ports; table 1 (B) reads in_a on the
    // primary port (five-input function, memory) and in_b on the secondary.
    generate
        for (genvar t = 0; t < N_TAB; t++) begin : g_tab
            cfg_slice_table #(
                .IDX_W (IDX_W)
            ) u_table (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_we   (cfg_we && (cfg_sel == t[0])),
                .load_word (cfg_init),
                .bit_we    (ram_wr),
                .bit_addr  (in_a),
                .bit_d     (ram_wdata[t]),
                .rd_addr_p (in_a),
                .rd_addr_s ((t == 0) ? in_a : in_b),
                .rd_p      (rd_p[t]),
                .rd_s      (rd_s[t])
            );
        end
    endgenerate

    cfg_slice_ripple #(
        .W (ARITH_W)
    ) u_ripple (
        .op_a (in_a[ARITH_W-1:0]),
        .op_b (in_b[ARITH_W-1:0]),
        .cin  (carry_in),
        .sub  (arith_sub),
        .sum  (a_sum),
        .cout (a_cout),
        .ge   (a_ge),
        .ne   (a_ne),
        .le   (a_le)
    );

    // Output selection per mode.
    always_comb begin
        out_f0    = 1'b0;
        out_f1    = 1'b0;
        out_f5    = 1'b0;
        carry_out = 1'b0;
        cmp_ge    = 1'b0;
        cmp_ne    = 1'b0;
        cmp_le    = 1'b0;
        unique case (mode)
            MODE_LOGIC: begin
                out_f0 = rd_p[0];
                out_f1 = rd_s[1];
                out_f5 = in_sel ? rd_p[1] : rd_s[0];
            end
            MODE_ARITH: begin
                out_f0    = a_sum[0];
                out_f1    = a_sum[1];
                carry_out = a_cout;
                cmp_ge    = a_ge;
                cmp_ne    = a_ne;
                cmp_le    = a_le;
            end
            MODE_RAM: begin
                out_f0 = rd_p[0];
                out_f1 = rd_p[1];
            end
            MODE_ROM: begin
                out_f0 = rd_p[0];
                out_f1 = rd_s[1];
            end
        endcase
    end

    assign mode_q = mode;

endmodule

// File: rtl/cfg_slice_chk.sv
module cfg_slice_chk #(
    parameter int HAS_RAM = 1,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             mode_we,
    input logic [1:0]       mode_req,
    input logic [IDX_W-1:0] in_a,
    input logic             ram_we,
    input logic [1:0]       ram_wdata,
    input logic [1:0]       mode_q,
    input logic             mode_err,
    input logic             out_f0,
    input logic             out_f1,
    input logic             out_f5,
    input logic             carry_out,
    input logic             cmp_ge,
    input logic             cmp_ne,
    input logic             cmp_le
);

    logic req_ok;
    assign req_ok = (mode_req != 2'b10) || (HAS_RAM != 0);

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_q)); // R2

    AST_MODE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && req_ok) |=> (mode_q == $past(mode_req)) && !mode_err); // R2

    AST_RAM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !req_ok) |=> mode_err && $stable(mode_q)); // R11

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_err)); // R12

    AST_F5_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b00) |-> !out_f5); // R4

    AST_ARITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b01) |-> !carry_out && !cmp_ge && !cmp_ne && !cmp_le); // R7

    AST_CMP_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b01) |-> (cmp_ne == !(cmp_ge && cmp_le))); // R7

    AST_RAM_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10 && ram_we && !cfg_we && !mode_we)
        |=> (!$stable(in_a) || ({out_f1, out_f0} == $past(ram_wdata)))); // R8

endmodule

bind cfg_slice cfg_slice_chk #(
    .HAS_RAM (HAS_RAM),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .mode_we   (mode_we),
    .mode_req  (mode_req),
    .in_a      (in_a),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .mode_q    (mode_q),
    .mode_err  (mode_err),
    .out_f0    (out_f0),
    .out_f1    (out_f1),
    .out_f5    (out_f5),
    .carry_out (carry_out),
    .cmp_ge    (cmp_ge),
    .cmp_ne    (cmp_ne),
    .cmp_le    (cmp_le)
);

// File: tb/cfg_slice_bench.sv
`timescale 1ns/1ps
module cfg_slice_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_init = '0;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_req = '0;
    logic [3:0]  in_a = '0;
    logic [3:0]  in_b = '0;
    logic        in_sel = 1'b0;
    logic        carry_in = 1'b0;
    logic        arith_sub = 1'b0;
    logic        ram_we = 1'b0;
    logic [1:0]  ram_wdata = '0;

    logic [1:0] f_mode, l_mode;
    logic       f_err, l_err;
    logic       f_f0, f_f1, f_f5, f_co, f_ge, f_ne, f_le;
    logic       l_f0, l_f1, l_f5, l_co, l_ge, l_ne, l_le;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the table contents (full and reduced instances).
    logic [15:0] m_a = '0, m_b = '0;
    logic [15:0] r_a = '0, r_b = '0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_slice #(.HAS_RAM(1)) u_cfg_slice (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_init(cfg_init), .mode_we(mode_we), .mode_req(mode_req),
        .in_a(in_a), .in_b(in_b), .in_sel(in_sel), .carry_in(carry_in),
        .arith_sub(arith_sub), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .mode_q(f_mode), .mode_err(f_err), .out_f0(f_f0), .out_f1(f_f1),
        .out_f5(f_f5), .carry_out(f_co), .cmp_ge(f_ge), .cmp_ne(f_ne),
        .cmp_le(f_le)
    );

    cfg_slice #(.HAS_RAM(0)) u_cfg_slice_lite (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_init(cfg_init), .mode_we(mode_we), .mode_req(mode_req),
        .in_a(in_a), .in_b(in_b), .in_sel(in_sel), .carry_in(carry_in),
        .arith_sub(arith_sub), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .mode_q(l_mode), .mode_err(l_err), .out_f0(l_f0), .out_f1(l_f1),
        .out_f5(l_f5), .carry_out(l_co), .cmp_ge(l_ge), .cmp_ne(l_ne),
        .cmp_le(l_le)
    );

    // Arithmetic vectors: {a[1:0], b[1:0], cin, sub, cout, s1, s0, ge, ne, le}
    localparam logic [11:0] ARITH_VEC [8] = '{
        12'b01_10_0_0_011_011,
        12'b11_11_1_0_111_101,
        12'b10_11_0_0_101_011,
        12'b11_01_1_1_110_110,
        12'b01_10_1_1_011_011,
        12'b00_00_1_1_100_101,
        12'b10_00_0_1_101_110,
        12'b00_11_0_0_011_011
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_we  = 1'b1;
        mode_req = m;
        @(negedge clk);
        mode_we  = 1'b0;
        #1;
    endtask

    task automatic load(input logic sel, input logic [15:0] word);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = sel;
        cfg_init = word;
        @(negedge clk);
        cfg_we   = 1'b0;
        #1;
        if (sel) begin m_b = word; r_b = word; end
        else     begin m_a = word; r_a = word; end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 mode", f_mode, 2'b00);
        check("R1 err", f_err, 1'b0);
        check("R1 lite err", l_err, 1'b0);
        for (int i = 0; i < 16; i += 5) begin
            in_a = i[3:0]; in_b = i[3:0]; in_sel = i[0];
            #1;
            check("R1 outs", {f_f0, f_f1, f_f5}, 3'b000);
        end

        // R10: table loads
        load(1'b0, 16'hA5C3);
        load(1'b1, 16'h0FF0);

        // R3, R4: lookup and five-input function
        for (int i = 0; i < 16; i += 3) begin
            @(negedge clk);
            in_a = i[3:0]; in_b = 4'(15 - i); in_sel = 1'b0;
            #1;
            check("R3 f0", f_f0, m_a[i]);
            check("R3 f1", f_f1, m_b[15 - i]);
            check("R4 f5 sel0", f_f5, m_a[i]);
            in_sel = 1'b1;
            #1;
            check("R4 f5 sel1", f_f5, m_b[i]);
        end

        // R9: memory write strobe ignored in LOGIC mode
        @(negedge clk);
        in_a = 4'd6; in_b = 4'd6; in_sel = 1'b0;
        ram_we = 1'b1; ram_wdata = ~{m_b[6], m_a[6]};
        @(negedge clk);
        ram_we = 1'b0;
        #1;
        check("R9 logic no write f0", f_f0, m_a[6]);
        check("R9 logic no write f1", f_f1, m_b[6]);

        // R2, R5, R6, R7: arithmetic table
        set_mode(2'b01);
        check("R2 arith mode", f_mode, 2'b01);
        check("R2 lite arith mode", l_mode, 2'b01);
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            v = ARITH_VEC[i];
            @(negedge clk);
            in_a      = {2'b00, v[11:10]};
            in_b      = {2'b00, v[9:8]};
            carry_in  = v[7];
            arith_sub = v[6];
            #1;
            if (v[6]) check("R6 sub result", {f_co, f_f1, f_f0}, v[5:3]);
            else      check("R5 add result", {f_co, f_f1, f_f0}, v[5:3]);
            check("R7 compares", {f_ge, f_ne, f_le}, v[2:0]);
            check("R4 f5 idle", f_f5, 1'b0);
        end
        carry_in = 1'b0; arith_sub = 1'b0;

        // R9: ROM mode reads and ignores memory writes
        set_mode(2'b11);
        check("R2 rom mode", f_mode, 2'b11);
        in_a = 4'd12; in_b = 4'd3;
        #1;
        check("R9 rom f0", f_f0, m_a[12]);
        check("R9 rom f1", f_f1, m_b[3]);
        check("R7 rom cmp idle", {f_co, f_ge, f_ne, f_le}, 4'b0000);
        @(negedge clk);
        ram_we = 1'b1; ram_wdata = ~{m_b[12], m_a[12]};
        in_b = 4'd12;
        @(negedge clk);
        ram_we = 1'b0;
        #1;
        check("R9 rom no write f0", f_f0, m_a[12]);
        check("R9 rom no write f1", f_f1, m_b[12]);

        // R11: reduced cell refuses RAM; full cell accepts
        set_mode(2'b10);
        check("R2 ram mode", f_mode, 2'b10);
        check("R12 full err", f_err, 1'b0);
        check("R11 lite mode kept", l_mode, 2'b11);
        check("R11 lite err", l_err, 1'b1);

        // R8: asynchronous read, synchronous write
        @(negedge clk);
        in_a = 4'd5; in_b = 4'd5;
        ram_we = 1'b1; ram_wdata = 2'b01;
        #1;
        check("R8 read before write", {f_f1, f_f0}, {m_b[5], m_a[5]});
        @(negedge clk);
        ram_we = 1'b0;
        m_a[5] = 1'b1; m_b[5] = 1'b0;
        #1;
        check("R8 read after write", {f_f1, f_f0}, 2'b01);
        check("R9 lite rom untouched", {l_f1, l_f0}, {r_b[5], r_a[5]});
        check("R12 lite err held", l_err, 1'b1);

        // R10: table load beats a simultaneous memory write
        @(negedge clk);
        in_a = 4'd9; in_b = 4'd9;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_init = 16'h1234;
        ram_we = 1'b1; ram_wdata = 2'b00;
        @(negedge clk);
        cfg_we = 1'b0; ram_we = 1'b0;
        m_a = 16'h1234; r_a = 16'h1234;
        #1;
        check("R10 load wins f0", f_f0, m_a[9]);
        check("R10 load wins f1", f_f1, m_b[9]);
        in_a = 4'd5;
        #1;
        check("R10 whole word replaced", {f_f1, f_f0}, {m_b[5], m_a[5]});

        // R12: accepted request clears the error
        set_mode(2'b00);
        check("R2 back to logic", f_mode, 2'b00);
        check("R12 lite err cleared", l_err, 1'b0);
        check("R12 lite mode", l_mode, 2'b00);
        in_a = 4'd9; in_b = 4'd9;
        #1;
        check("R3 lite after reload", l_f0, r_a[9]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule